// File: doc/BRIEF.md
# Ternary Truth Vector Match Scorer

This block grades a set of candidate wires against a set of target ternary functions. Every wire and every target is a full truth vector over `N_VARS` ternary inputs, so each has 3^N_VARS entries of two bits. Target entries may be marked as don't care. For each target the block looks for the wire that matches best. It grants partial credit through a hierarchy of aligned sub-blocks and adds a bonus when a wire matches the whole vector. It then adds three weighted cost terms computed from counts that the caller supplies: unused constant lines, pass-through columns, and identity maps inside active columns. The result is an unsigned fixed-point fitness with 8 fractional bits. The block also reports whether every target was fully realised, whether the fitness passes the solution threshold, and which wire scored best for each target.

A run begins with a one-cycle `start` while the block is in `ST_IDLE` or `ST_DONE`. The controller then moves through the following states:
- `ST_SCAN` compares one wire per cycle against the current target and keeps running maxima.
- `ST_SUM` adds the finished target's score. It goes back to `ST_SCAN` for the next target, or on to `ST_DIV_WIDTH` after the last target.
- `ST_DIV_WIDTH`, `ST_DIV_COL` and `ST_DIV_IDENT` each compute one cost term on a shared serial divider. Each state advances when the divider finishes.
- `ST_DONE` raises `valid` and holds the results. A new `start` returns the block to `ST_SCAN`.

All data inputs must be held stable from `start` until `valid` is high.

Top module: `tv_match_scorer`

## Requirements
- R1: Entry `e` of wire `w` sits at bits `[(w*LEN+e)*2 +: 2]` of `wire_tv`, and targets are packed the same way in `target_tv`. A target code of 3 matches any wire value. Target codes 0 to 2 match only an equal wire value.
- R2: Level `i` runs from 1 to N_VARS. It divides a vector into 3^i aligned sub-blocks of 3^(N_VARS-i) entries each, and sub-block `j` starts at entry `j*3^(N_VARS-i)`. A sub-block matches only if every entry in it matches. The level credit equals floor(256*count/3^i).
- R3: For each target and each level, the block takes the largest matching count over all wires. Each level takes its maximum independently, so different levels may use different wires.
- R4: A target earns a bonus of 256 (1.0) when at least one wire matches all of its entries. A fully realised target therefore scores (N_VARS+1)*256. `all_realised` is 1 exactly when every target earned the bonus.
- R5: A wire's own score is its bonus plus its level credits. `best_wire` field `o` (WIDX bits, target `o` at the low end) holds the wire with the highest own score. On a tie the lower-numbered wire wins.
- R6: The width term is floor(128*`const_unused`/`const_total`). It is 0 when `const_total` is 0.
- R7: The column term is floor(102*`pass_cols`/`casc_len`). It is 0 when `casc_len` is 0.
- R8: The identity term is floor(25*`ident_maps`/(3*(`casc_len`-`pass_cols`))). It is 0 when `pass_cols` is greater than or equal to `casc_len`.
- R9: `fitness` is the sum of all target scores and the three terms, saturated at 65535. `is_solution` is 1 when `fitness` exceeds N_OUTS*(N_VARS+1)*256.
- R10: After reset, `valid` is 0 and `fitness` is 0. The cycle after an accepted `start`, `valid` is 0. Once `valid` rises, it stays high with all results unchanged until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scoring run |
| wire_tv | input | N_WIRES*2*LEN | Truth vectors of all wires |
| target_tv | input | N_OUTS*2*LEN | Target vectors, code 3 = don't care |
| const_total | input | CNT_W | Number of constant lines |
| const_unused | input | CNT_W | Unused constant lines |
| casc_len | input | CNT_W | Cascade length in columns |
| pass_cols | input | CNT_W | Pass-through columns |
| ident_maps | input | CNT_W | Identity maps in active columns |
| valid | output | 1 | Results ready and held |
| fitness | output | FIT_W | Fixed-point fitness, 8 fractional bits |
| all_realised | output | 1 | Every target fully matched |
| is_solution | output | 1 | Fitness above the solution threshold |
| best_wire | output | N_OUTS*WIDX | Best wire index per target |

## Verification
The test patterns are chosen so that each one exposes a different class of fault:
- Exact copies of the two half-adder outputs on some wires show whether full matches and the bonus are detected.
- Wires that each match different sub-blocks of the same target separate a per-level maximum from a single best-wire credit.
- All-don't-care targets make every wire a perfect match, which exposes how ties are broken and whether code 3 is honoured.
- Mixed don't-care targets, with two identical wires, show both partial don't-care matching and the lower-index tie rule.
- Zero denominators show whether each cost term is suppressed.
- Saturated counts check the truncation of the weighted terms.

// File: rtl/tvs_pkg.sv
package tvs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_SUM,
        ST_DIV_WIDTH,
        ST_DIV_COL,
        ST_DIV_IDENT,
        ST_DONE
    } tvs_state_e;

    localparam int RECIP_SHIFT = 24;

    function automatic int pow3(input int e);
        int r;
        r = 1;
        for (int k = 0; k < e; k++) r = r * 3;
        return r;
    endfunction

    // ceil(2^RECIP_SHIFT / d): exact floor division for the small numerators used here
    function automatic longint recip(input int d);
        longint one;
        one = longint'(1) <<< RECIP_SHIFT;
        return (one + longint'(d) - 1) / longint'(d);
    endfunction

endpackage

// File: rtl/tvs_match.sv
module tvs_match
    import tvs_pkg::*;
#(
    parameter int N_VARS = 2,
    localparam int LEN = pow3(N_VARS),
    localparam int CW  = $clog2(LEN + 1)
) (
    input  logic [2*LEN-1:0]          wire_v,
    input  logic [2*LEN-1:0]          tgt_v,
    output logic [N_VARS:1][CW-1:0]   lvl_cnt,
    output logic                      full_match
);

    // Level tree: finest level compares entries, coarser levels AND triplets.
    for (genvar g = N_VARS; g >= 0; g--) begin : lv
        localparam int NB = pow3(g);
        logic [NB-1:0] m;
        if (g == N_VARS) begin : leaf
            for (genvar e = 0; e < NB; e++) begin : ent
                assign m[e] = (tgt_v[2*e +: 2] == 2'd3) ||
                              (tgt_v[2*e +: 2] == wire_v[2*e +: 2]);
            end
        end else begin : node
            for (genvar j = 0; j < NB; j++) begin : blk
                assign m[j] = &lv[g+1].m[3*j +: 3];
            end
        end
    end

    for (genvar g = 1; g <= N_VARS; g++) begin : cnt
        assign lvl_cnt[g] = CW'($countones(lv[g].m));
    end

    assign full_match = lv[0].m[0];

endmodule

// File: rtl/tvs_credit.sv
module tvs_credit
    import tvs_pkg::*;
#(
    parameter int N_VARS = 2,
    parameter int FIT_W  = 16,
    parameter int FRAC   = 8,
    localparam int LEN = pow3(N_VARS),
    localparam int CW  = $clog2(LEN + 1)
) (
    input  logic [N_VARS:1][CW-1:0] lvl_cnt,
    input  logic                    full_match,
    output logic [FIT_W-1:0]        score
);

    localparam int PW = CW + FRAC + RECIP_SHIFT + 2;

    logic [N_VARS:1][FIT_W-1:0] term;

    for (genvar g = 1; g <= N_VARS; g++) begin : lvl
        localparam logic [RECIP_SHIFT:0] RCP = (RECIP_SHIFT+1)'(recip(pow3(g)));
        logic [PW-1:0] prod;
        assign prod    = (PW'(lvl_cnt[g]) << FRAC) * PW'(RCP);
        assign term[g] = FIT_W'(prod >> RECIP_SHIFT);
    end

    always_comb begin
        score = full_match ? (FIT_W'(1) << FRAC) : '0;
        for (int g = 1; g <= N_VARS; g++) score = score + term[g];
    end

endmodule

// File: rtl/tvs_divider.sv
module tvs_divider #(
    parameter int NUM_W = 16,
    parameter int DEN_W = 10,
    localparam int CNT_BITS = $clog2(NUM_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);

    logic [DEN_W-1:0]    rem;
    logic [DEN_W-1:0]    den_q;
    logic [CNT_BITS-1:0] steps;
    logic                run;
    logic [DEN_W:0]      trial;

    assign trial = {rem, quo[NUM_W-1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem   <= '0;
            den_q <= '0;
            steps <= '0;
            run   <= 1'b0;
            done  <= 1'b0;
            quo   <= '0;
        end else if (go) begin
            rem   <= '0;
            den_q <= den;
            steps <= CNT_BITS'(NUM_W);
            if (den == '0) begin
                quo  <= '0;
                run  <= 1'b0;
                done <= 1'b1;
            end else begin
                quo  <= num;
                run  <= 1'b1;
                done <= 1'b0;
            end
        end else if (run) begin
            if (trial >= {1'b0, den_q}) begin
                rem <= DEN_W'(trial - {1'b0, den_q});
                quo <= {quo[NUM_W-2:0], 1'b1};
            end else begin
                rem <= trial[DEN_W-1:0];
                quo <= {quo[NUM_W-2:0], 1'b0};
            end
            steps <= steps - 1'b1;
            if (steps == CNT_BITS'(1)) begin
                run  <= 1'b0;
                done <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end

endmodule

// File: rtl/tv_match_scorer.sv
module tv_match_scorer
    import tvs_pkg::*;
#(
    parameter int N_VARS   = 2,
    parameter int N_WIRES  = 4,
    parameter int N_OUTS   = 2,
    parameter int CNT_W    = 8,
    parameter int FIT_W    = 16,
    parameter int FRAC     = 8,
    parameter int WT_WIDTH = 5,
    parameter int WT_COL   = 4,
    parameter int WT_IDENT = 1,
    localparam int LEN  = pow3(N_VARS),
    localparam int TV_W = 2 * LEN,
    localparam int WIDX = (N_WIRES > 1) ? $clog2(N_WIRES) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [N_WIRES*TV_W-1:0]   wire_tv,
    input  logic [N_OUTS*TV_W-1:0]    target_tv,
    input  logic [CNT_W-1:0]          const_total,
    input  logic [CNT_W-1:0]          const_unused,
    input  logic [CNT_W-1:0]          casc_len,
    input  logic [CNT_W-1:0]          pass_cols,
    input  logic [CNT_W-1:0]          ident_maps,
    output logic                      valid,
    output logic [FIT_W-1:0]          fitness,
    output logic                      all_realised,
    output logic                      is_solution,
    output logic [N_OUTS*WIDX-1:0]    best_wire
);

    localparam int CW      = $clog2(LEN + 1);
    localparam int OIDX    = (N_OUTS > 1) ? $clog2(N_OUTS) : 1;
    localparam int NUM_W   = CNT_W + FRAC;
    localparam int DEN_W   = CNT_W + 2;
    localparam int ACC_W   = FIT_W + NUM_W;
    localparam int Q_WIDTH = (WT_WIDTH << FRAC) / 10;
    localparam int Q_COL   = (WT_COL << FRAC) / 10;
    localparam int Q_IDENT = (WT_IDENT << FRAC) / 10;
    localparam int THRESH  = (N_OUTS * (N_VARS + 1)) << FRAC;
    localparam logic [ACC_W-1:0] FIT_MAX = ACC_W'((64'(1) << FIT_W) - 1);

    tvs_state_e state, state_nxt;

    logic [OIDX-1:0]              out_idx;
    logic [WIDX-1:0]              wire_idx;
    logic [N_VARS:1][CW-1:0]      max_cnt;
    logic                         full_any;
    logic [FIT_W-1:0]             best_score;
    logic [WIDX-1:0]              best_idx;
    logic [ACC_W-1:0]             acc;
    logic                         all_ok;

    logic [TV_W-1:0]              cur_wire;
    logic [TV_W-1:0]              cur_tgt;
    logic [N_VARS:1][CW-1:0]      w_cnt;
    logic                         w_full;
    logic [FIT_W-1:0]             w_score;
    logic [FIT_W-1:0]             o_score;

    logic                         div_go;
    logic [NUM_W-1:0]             div_num;
    logic [DEN_W-1:0]             div_den;
    logic                         div_done;
    logic [NUM_W-1:0]             div_quo;
    logic [CNT_W-1:0]             active_cols;

    logic last_wire, last_out;

    assign last_wire = (wire_idx == WIDX'(N_WIRES - 1));
    assign last_out  = (out_idx == OIDX'(N_OUTS - 1));
    assign cur_wire  = wire_tv[int'(wire_idx)*TV_W +: TV_W];
    assign cur_tgt   = target_tv[int'(out_idx)*TV_W +: TV_W];

    tvs_match #(.N_VARS(N_VARS)) u_match (
        .wire_v     (cur_wire),
        .tgt_v      (cur_tgt),
        .lvl_cnt    (w_cnt),
        .full_match (w_full)
    );

    tvs_credit #(.N_VARS(N_VARS), .FIT_W(FIT_W), .FRAC(FRAC)) u_wire_credit (
        .lvl_cnt    (w_cnt),
        .full_match (w_full),
        .score      (w_score)
    );

    tvs_credit #(.N_VARS(N_VARS), .FIT_W(FIT_W), .FRAC(FRAC)) u_out_credit (
        .lvl_cnt    (max_cnt),
        .full_match (full_any),
        .score      (o_score)
    );

    // Operands of the shared divider, chosen by the cost-term state
    assign active_cols = (pass_cols >= casc_len) ? '0 : (casc_len - pass_cols);

    always_comb begin
        div_num = '0;
        div_den = '0;
        unique case (state)
            ST_DIV_WIDTH: begin
                div_num = NUM_W'(Q_WIDTH) * NUM_W'(const_unused);
                div_den = DEN_W'(const_total);
            end
            ST_DIV_COL: begin
                div_num = NUM_W'(Q_COL) * NUM_W'(pass_cols);
                div_den = DEN_W'(casc_len);
            end
            ST_DIV_IDENT: begin
                div_num = NUM_W'(Q_IDENT) * NUM_W'(ident_maps);
                div_den = DEN_W'(3) * DEN_W'(active_cols);
            end
            default: begin
                div_num = '0;
                div_den = '0;
            end
        endcase
    end

    tvs_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .num   (div_num),
        .den   (div_den),
        .done  (div_done),
        .quo   (div_quo)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:      if (start)     state_nxt = ST_SCAN;
            ST_SCAN:      if (last_wire) state_nxt = ST_SUM;
            ST_SUM:       state_nxt = last_out ? ST_DIV_WIDTH : ST_SCAN;
            ST_DIV_WIDTH: if (div_done)  state_nxt = ST_DIV_COL;
            ST_DIV_COL:   if (div_done)  state_nxt = ST_DIV_IDENT;
            ST_DIV_IDENT: if (div_done)  state_nxt = ST_DONE;
            ST_DONE:      if (start)     state_nxt = ST_SCAN;
            default:      state_nxt = ST_IDLE;
        endcase
    end

    // Datapath and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_idx    <= '0;
            wire_idx   <= '0;
            max_cnt    <= '0;
            full_any   <= 1'b0;
            best_score <= '0;
            best_idx   <= '0;
            acc        <= '0;
            all_ok     <= 1'b0;
            best_wire  <= '0;
            valid      <= 1'b0;
            div_go     <= 1'b0;
        end else begin
            div_go <= 1'b0;
            unique case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        out_idx    <= '0;
                        wire_idx   <= '0;
                        max_cnt    <= '0;
                        full_any   <= 1'b0;
                        best_score <= '0;
                        best_idx   <= '0;
                        acc        <= '0;
                        all_ok     <= 1'b1;
                        valid      <= 1'b0;
                    end
                end
                ST_SCAN: begin
                    for (int g = 1; g <= N_VARS; g++) begin
                        if (w_cnt[g] > max_cnt[g]) max_cnt[g] <= w_cnt[g];
                    end
                    full_any <= full_any | w_full;
                    if (wire_idx == '0 || w_score > best_score) begin
                        best_score <= w_score;
                        best_idx   <= wire_idx;
                    end
                    if (!last_wire) wire_idx <= wire_idx + 1'b1;
                end
                ST_SUM: begin
                    acc    <= acc + ACC_W'(o_score);
                    all_ok <= all_ok & full_any;
                    best_wire[int'(out_idx)*WIDX +: WIDX] <= best_idx;
                    if (last_out) begin
                        div_go <= 1'b1;
                    end else begin
                        out_idx    <= out_idx + 1'b1;
                        wire_idx   <= '0;
                        max_cnt    <= '0;
                        full_any   <= 1'b0;
                        best_score <= '0;
                        best_idx   <= '0;
                    end
                end
                ST_DIV_WIDTH, ST_DIV_COL: begin
                    if (div_done) begin
                        acc    <= acc + ACC_W'(div_quo);
                        div_go <= 1'b1;
                    end
                end
                ST_DIV_IDENT: begin
                    if (div_done) begin
                        acc   <= acc + ACC_W'(div_quo);
                        valid <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign fitness      = (acc > FIT_MAX) ? '1 : acc[FIT_W-1:0];
    assign all_realised = valid & all_ok;
    assign is_solution  = valid & (fitness > FIT_W'(THRESH));

endmodule

// File: rtl/tvs_checker.sv
module tvs_checker #(
    parameter int N_VARS = 2,
    parameter int N_OUTS = 2,
    parameter int FIT_W  = 16,
    parameter int FRAC   = 8,
    parameter int BW_W   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             valid,
    input logic [FIT_W-1:0] fitness,
    input logic             all_realised,
    input logic [BW_W-1:0]  best_wire
);

    localparam int THRESH = (N_OUTS * (N_VARS + 1)) << FRAC;

    assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !valid);

    assert_valid_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !start) |=> valid);

    assert_result_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !start) |=> ($stable(fitness) && $stable(best_wire) && $stable(all_realised)));

    assert_realised_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        all_realised |-> (fitness >= FIT_W'(THRESH)));

endmodule

bind tv_match_scorer tvs_checker #(
    .N_VARS (N_VARS),
    .N_OUTS (N_OUTS),
    .FIT_W  (FIT_W),
    .FRAC   (FRAC),
    .BW_W   (N_OUTS * WIDX)
) u_tvs_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .valid        (valid),
    .fitness      (fitness),
    .all_realised (all_realised),
    .best_wire    (best_wire)
);

// File: tb/tb_tv_match_scorer.sv
module tb_tv_match_scorer;

    localparam int CLK_PERIOD = 10;
    localparam int NV  = 2;
    localparam int NW  = 4;
    localparam int NO  = 2;
    localparam int TVW = 18;
    localparam int WX  = 2;

    typedef struct packed {
        logic [NW*TVW-1:0] wv;
        logic [NO*TVW-1:0] tv;
        logic [7:0] tot;
        logic [7:0] unu;
        logic [7:0] len;
        logic [7:0] pas;
        logic [7:0] idn;
        logic       exp_all;
    } case_t;

    function automatic logic [17:0] tv9(input int e0, input int e1, input int e2,
                                        input int e3, input int e4, input int e5,
                                        input int e6, input int e7, input int e8);
        return {2'(e8), 2'(e7), 2'(e6), 2'(e5), 2'(e4), 2'(e3), 2'(e2), 2'(e1), 2'(e0)};
    endfunction

    localparam logic [17:0] HA_C  = tv9(0,0,0,0,0,1,0,1,1);
    localparam logic [17:0] HA_S  = tv9(0,1,2,1,2,0,2,0,1);
    localparam logic [17:0] ROWS  = tv9(0,0,0,1,1,1,2,2,2);
    localparam logic [17:0] COLS  = tv9(0,1,2,0,1,2,0,1,2);
    localparam logic [17:0] PB0   = tv9(0,0,0,2,2,2,2,2,2);
    localparam logic [17:0] PB1   = tv9(1,1,1,0,0,1,0,1,1);
    localparam logic [17:0] PB2   = tv9(0,1,2,0,0,0,0,0,0);
    localparam logic [17:0] PB3   = tv9(2,2,2,2,2,2,2,2,0);
    localparam logic [17:0] ALLDC = tv9(3,3,3,3,3,3,3,3,3);
    localparam logic [17:0] DC_T0 = tv9(3,3,3,0,0,1,0,1,1);
    localparam logic [17:0] DC_T1 = tv9(0,1,2,3,3,3,2,1,0);
    localparam logic [17:0] DW0   = tv9(1,1,1,1,1,1,1,1,1);
    localparam logic [17:0] DW1   = tv9(2,1,0,0,0,1,0,1,1);
    localparam logic [17:0] DW3   = tv9(0,1,2,2,2,2,2,1,0);

    // wires {w3,w2,w1,w0}, targets {t1,t0}, tot, unused, len, pass, ident, expected all_realised
    localparam case_t CASES [6] = '{
        '{ {COLS, HA_S, HA_C, ROWS}, {HA_S, HA_C}, 8'd3, 8'd2, 8'd4, 8'd0, 8'd5, 1'b1 },   // exact copies R4
        '{ {PB3, PB2, PB1, PB0}, {HA_S, HA_C}, 8'd6, 8'd0, 8'd6, 8'd2, 8'd3, 1'b0 },      // split blocks R3
        '{ {PB3, COLS, HA_S, ROWS}, {ALLDC, ALLDC}, 8'd3, 8'd1, 8'd5, 8'd1, 8'd7, 1'b1 }, // all don't care R1 R5
        '{ {DW3, DW1, DW1, DW0}, {DC_T1, DC_T0}, 8'd9, 8'd4, 8'd7, 8'd3, 8'd2, 1'b1 },    // mixed don't care, tie R1 R5
        '{ {COLS, HA_S, HA_C, ROWS}, {HA_S, HA_C}, 8'd0, 8'd0, 8'd0, 8'd0, 8'd9, 1'b1 },  // zero denominators R6 R7 R8
        '{ {PB3, PB2, PB1, PB0}, {HA_S, HA_C}, 8'd255, 8'd255, 8'd10, 8'd5, 8'd15, 1'b0 } // full-scale terms R6 R7 R8
    };

    logic                 clk;
    logic                 rst_n;
    logic                 start;
    logic [NW*TVW-1:0]    wire_tv;
    logic [NO*TVW-1:0]    target_tv;
    logic [7:0]           const_total, const_unused, casc_len, pass_cols, ident_maps;
    logic                 valid;
    logic [15:0]          fitness;
    logic                 all_realised;
    logic                 is_solution;
    logic [NO*WX-1:0]     best_wire;

    int checks = 0;
    int failures = 0;

    tv_match_scorer dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .wire_tv      (wire_tv),
        .target_tv    (target_tv),
        .const_total  (const_total),
        .const_unused (const_unused),
        .casc_len     (casc_len),
        .pass_cols    (pass_cols),
        .ident_maps   (ident_maps),
        .valid        (valid),
        .fitness      (fitness),
        .all_realised (all_realised),
        .is_solution  (is_solution),
        .best_wire    (best_wire)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Independent reference of the scoring rules
    task automatic model(input case_t c, output int fit, output bit allr, output int bw [NO]);
        int acc;
        acc  = 0;
        allr = 1'b1;
        for (int o = 0; o < NO; o++) begin
            int mx [NV+1];
            bit fany;
            int bscore;
            int bidx;
            fany = 1'b0; bscore = -1; bidx = 0;
            for (int i = 0; i <= NV; i++) mx[i] = 0;
            for (int w = 0; w < NW; w++) begin
                int ws;
                bit wfull;
                ws = 0; wfull = 1'b0;
                for (int i = 1; i <= NV; i++) begin
                    int nb, sz, cnt;
                    nb = 3**i; sz = 3**(NV-i); cnt = 0;
                    for (int j = 0; j < nb; j++) begin
                        bit ok;
                        ok = 1'b1;
                        for (int e = j*sz; e < (j+1)*sz; e++) begin
                            logic [1:0] t, v;
                            t = c.tv[o*TVW + 2*e +: 2];
                            v = c.wv[w*TVW + 2*e +: 2];
                            if (!(t == 2'd3 || t == v)) ok = 1'b0;
                        end
                        if (ok) cnt++;
                    end
                    if (cnt > mx[i]) mx[i] = cnt;
                    if (i == 1 && cnt == 3) wfull = 1'b1;
                    ws += (cnt * 256) / nb;
                end
                if (wfull) begin
                    ws += 256;
                    fany = 1'b1;
                end
                if (ws > bscore) begin
                    bscore = ws;
                    bidx = w;
                end
            end
            bw[o] = bidx;
            if (fany) acc += 256;
            for (int i = 1; i <= NV; i++) acc += (mx[i] * 256) / (3**i);
            allr &= fany;
        end
        if (c.tot != 0) acc += (128 * int'(c.unu)) / int'(c.tot);
        if (c.len != 0) acc += (102 * int'(c.pas)) / int'(c.len);
        if (c.pas < c.len) acc += (25 * int'(c.idn)) / (3 * (int'(c.len) - int'(c.pas)));
        fit = (acc > 65535) ? 65535 : acc;
    endtask

    task automatic apply(input case_t c);
        wire_tv      = c.wv;
        target_tv    = c.tv;
        const_total  = c.tot;
        const_unused = c.unu;
        casc_len     = c.len;
        pass_cols    = c.pas;
        ident_maps   = c.idn;
    endtask

    task automatic run_and_wait(output bit ok);
        int n;
        n = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!valid && n < 5000) begin
            @(negedge clk);
            n++;
        end
        ok = valid;
    endtask

    task automatic run_case(input case_t c, input int idx);
        int  efit;
        bit  eall;
        int  ebw [NO];
        bit  ok;
        @(negedge clk);
        apply(c);
        run_and_wait(ok);
        check($sformatf("R10 case%0d completes", idx), int'(ok), 1);
        model(c, efit, eall, ebw);
        check($sformatf("R2 R3 R6 R7 R8 R9 case%0d fitness", idx), int'(fitness), efit);
        check($sformatf("R4 case%0d all_realised vs model", idx), int'(all_realised), int'(eall));
        check($sformatf("R4 case%0d all_realised vs table", idx), int'(all_realised), int'(c.exp_all));
        check($sformatf("R9 case%0d is_solution", idx), int'(is_solution), int'(efit > NO*(NV+1)*256));
        for (int o = 0; o < NO; o++)
            check($sformatf("R5 case%0d best_wire[%0d]", idx, o), int'(best_wire[o*WX +: WX]), ebw[o]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R10 actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit ok;
        logic [15:0] held_fit;
        rst_n = 1'b0;
        start = 1'b0;
        apply(CASES[0]);
        repeat (3) @(negedge clk);
        // Reset state R10
        check("R10 reset valid", int'(valid), 0);
        check("R10 reset fitness", int'(fitness), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < 6; k++) run_case(CASES[k], k);

        // Hold after completion with start low R10
        held_fit = fitness;
        repeat (4) @(negedge clk);
        check("R10 valid held", int'(valid), 1);
        check("R10 fitness held", int'(fitness), int'(held_fit));

        // Restart drops valid on the next cycle R10
        apply(CASES[0]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 start clears valid", int'(valid), 0);
        begin
            int n;
            n = 0;
            while (!valid && n < 5000) begin
                @(negedge clk);
                n++;
            end
        end
        check("R10 restart completes", int'(valid), 1);
        check("R4 restart all_realised", int'(all_realised), 1);

        // Single-entry mismatch on the only exact wire removes the full bonus (R1 R4)
        begin
            case_t c;
            c = CASES[0];
            c.wv[1*TVW +: TVW] = tv9(0,0,0,0,0,1,0,1,2);
            c.wv[2*TVW +: TVW] = tv9(0,1,2,1,2,0,2,0,0);
            c.exp_all = 1'b0;
            run_case(c, 6);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule